// File: doc/BRIEF.md
# Cross-Clock Single-Pulse Synchronizer

This block carries a single-cycle event from a source clock domain into an unrelated destination clock domain. There it appears as a pulse exactly one destination-clock period wide. The two clocks come from independent oscillators and have no frequency or phase relation.

The event input is the output of an AND gate whose inputs come from source-domain flops, so it may glitch between source edges. The block looks at it only on the rising edge of the source clock. Each sampled event flips a source-domain state flop. The state of that flop crosses through a synchronizer chain in the destination domain. A change detector then drives the output from a destination-domain flop, so the output is glitch-free.

The external reset is asynchronous and active-high. Each domain has its own reset synchronizer: reset takes effect at once and is released on that domain's clock.

Top module: `xclk_pulse_bridge`

## Requirements
- R1: After reset is released and no event has been sampled, `dst_pulse` stays 0.
- R2: `src_evt` is sampled only on rising edges of `src_clk`. A high level that starts and ends between two rising edges produces no output pulse.
- R3: Each output pulse is high for exactly one `dst_clk` period.
- R4: With the default `SYNC_STAGES` = 2, `dst_pulse` rises more than 2 and at most 3 `dst_clk` periods after the `src_clk` edge that sampled the event.
- R5: Events at least 5 destination periods apart each produce exactly one output pulse.
- R6: R3, R4 and R5 hold both when `src_clk` is faster than `dst_clk` and when it is slower.
- R7: After the external reset falls, the source-domain internal reset releases on the `RST_STAGES`-th rising edge of `src_clk`. An event sampled on any of those first `RST_STAGES` edges is discarded. An event sampled on a later edge is carried across.
- R8: Raising `rst` forces `dst_pulse` to 0 at once, without waiting for a clock edge, and no pulse follows the next release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high reset, glitch-free |
| src_clk | input | 1 | Source-domain clock |
| dst_clk | input | 1 | Destination-domain clock |
| src_evt | input | 1 | Source-domain event, high for one source cycle, may glitch between edges |
| dst_pulse | output | 1 | Destination-domain pulse, one `dst_clk` period wide |

## Verification
The hardest case to reach is an event that arrives while the source domain is still coming out of reset. Reset has dropped, but the per-domain synchronizer has not yet released. The bench drops reset at a point unrelated to either clock and holds the event high across exactly the first two source edges that follow. It then checks that no pulse comes out, and that a later event is still carried across. A second hard case is a glitch that lies wholly between source edges. Short high spikes are placed inside the low phase of a fast source clock, and the bench confirms that they do not reach the output.

// File: rtl/xpb_pkg.sv
`timescale 1ns/1ps
package xpb_pkg;

    // Smallest synchronizer depth that gives metastability time to settle.
    localparam int MIN_SYNC_STAGES = 2;

    // Source-domain state: one flop that flips once per sampled event.
    typedef struct packed {
        logic tog;
    } src_state_t;

endpackage

// File: rtl/xpb_rst_sync.sv
`timescale 1ns/1ps
module xpb_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic rst_n
);

    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stage_d = 1'b1;
        end else begin : g_chain
            always_comb stage_d = {stage_q[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_ff @(posedge clk or posedge arst) begin
        if (arst) stage_q <= '0;
        else      stage_q <= stage_d;
    end

    assign rst_n = stage_q[STAGES-1];

    // R7
    release_order_chk: assert property (@(posedge clk) disable iff (arst)
        rst_n |-> stage_q[0]);

endmodule

// File: rtl/xpb_src_toggle.sv
`timescale 1ns/1ps
module xpb_src_toggle
    import xpb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic tog
);

    src_state_t state_d;
    src_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (evt) state_d.tog = ~state_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tog = state_q.tog;

    // R2
    tog_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q.tog) |-> $past(evt));

endmodule

// File: rtl/xpb_dst_detect.sv
`timescale 1ns/1ps
module xpb_dst_detect
    import xpb_pkg::*;
#(
    parameter int SYNC_STAGES = MIN_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_async,
    output logic pulse
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        logic                   pulse;
    } dst_state_t;

    dst_state_t state_d;
    dst_state_t state_q;

    always_comb begin
        state_d         = state_q;
        state_d.sync[0] = tog_async;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            state_d.sync[i] = state_q.sync[i-1];
        end
        state_d.last  = state_q.sync[LAST];
        state_d.pulse = state_q.sync[LAST] ^ state_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pulse = state_q.pulse;

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.pulse |=> !state_q.pulse);

    // R4
    edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.pulse |-> !$stable(state_q.last));

endmodule

// File: rtl/xclk_pulse_bridge.sv
`timescale 1ns/1ps
module xclk_pulse_bridge #(
    parameter int SYNC_STAGES = 2,
    parameter int RST_STAGES  = 2
) (
    input  logic rst,
    input  logic src_clk,
    input  logic dst_clk,
    input  logic src_evt,
    output logic dst_pulse
);

    logic src_rst_n;
    logic dst_rst_n;
    logic src_tog;

    xpb_rst_sync #(.STAGES(RST_STAGES)) u_src_rst (
        .clk   (src_clk),
        .arst  (rst),
        .rst_n (src_rst_n)
    );

    xpb_rst_sync #(.STAGES(RST_STAGES)) u_dst_rst (
        .clk   (dst_clk),
        .arst  (rst),
        .rst_n (dst_rst_n)
    );

    xpb_src_toggle u_src (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .evt   (src_evt),
        .tog   (src_tog)
    );

    xpb_dst_detect #(.SYNC_STAGES(SYNC_STAGES)) u_dst (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .tog_async (src_tog),
        .pulse     (dst_pulse)
    );

endmodule

// File: tb/xclk_pulse_bridge_test.sv
`timescale 1ns/1ps
module xclk_pulse_bridge_test;

    localparam realtime DST_PERIOD = 10.0;
    localparam realtime SLOW_SRC   = 37.3;
    localparam realtime FAST_SRC   = 3.1;
    localparam realtime EPS        = 0.0005;

    logic rst;
    logic src_clk;
    logic dst_clk;
    logic src_evt;
    logic dst_pulse;

    realtime src_period = SLOW_SRC;
    realtime exp_q[$];
    int      checks = 0;
    int      errors = 0;
    int      pulses = 0;
    bit      cut_ok = 0;

    xclk_pulse_bridge uut (
        .rst       (rst),
        .src_clk   (src_clk),
        .dst_clk   (dst_clk),
        .src_evt   (src_evt),
        .dst_pulse (dst_pulse)
    );

    initial begin
        dst_clk = 0;
        forever #(DST_PERIOD / 2) dst_clk = ~dst_clk;
    end

    initial begin
        src_clk = 0;
        forever #(src_period / 2) src_clk = ~src_clk;
    end

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic wait_dst(input int n);
        repeat (n) @(posedge dst_clk);
        #1;
    endtask

    // Driver: one event, high for one source cycle; the capture time goes to the scoreboard.
    task automatic fire_event();
        @(negedge src_clk);
        src_evt = 1;
        @(posedge src_clk);
        exp_q.push_back($realtime);
        #0.2;
        src_evt = 0;
        wait_dst(8);
    endtask

    // Monitor: pairs each output pulse with the oldest expected event.
    always begin
        realtime t_rise;
        realtime t_cap;
        realtime lat;
        realtime wid;
        @(posedge dst_pulse);
        t_rise = $realtime;
        pulses++;
        if (exp_q.size() == 0) begin
            check(0, "R1", $sformatf("unexpected pulse at %0t, actual 1 expected 0", $realtime));
        end else begin
            t_cap = exp_q.pop_front();
            lat = t_rise - t_cap;
            // R4 latency window, R6 across clock ratios
            check((lat > 2.0 * DST_PERIOD + EPS) && (lat < 3.0 * DST_PERIOD + EPS), "R4",
                  $sformatf("latency actual %0f expected (%0f,%0f]", lat,
                            2.0 * DST_PERIOD, 3.0 * DST_PERIOD));
        end
        @(negedge dst_pulse);
        if (!cut_ok) begin
            wid = $realtime - t_rise;
            check((wid > DST_PERIOD - EPS) && (wid < DST_PERIOD + EPS), "R3",
                  $sformatf("width actual %0f expected %0f", wid, DST_PERIOD));
        end
    end

    initial begin
        #(200000 * DST_PERIOD);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1;
        src_evt = 0;
        #50.3;
        rst = 0;
        wait_dst(10);
        // R1: idle after release
        check(dst_pulse == 0, "R1", $sformatf("output actual %0b expected 0", dst_pulse));
        check(pulses == 0, "R1", $sformatf("pulses actual %0d expected 0", pulses));

        // R6: slow source clock
        repeat (3) fire_event();
        wait_dst(5);
        check(pulses == 3, "R5", $sformatf("slow-source pulses actual %0d expected 3", pulses));

        // R2: glitches between source edges
        src_period = FAST_SRC;
        wait_dst(2);
        for (int i = 0; i < 20; i++) begin
            @(negedge src_clk);
            #0.4 src_evt = 1;
            #0.3 src_evt = 0;
        end
        wait_dst(10);
        check(pulses == 3, "R2", $sformatf("pulses after glitches actual %0d expected 3", pulses));
        check(dst_pulse == 0, "R2", $sformatf("output actual %0b expected 0", dst_pulse));

        // R6: fast source clock
        repeat (3) fire_event();
        wait_dst(5);
        check(pulses == 6, "R6", $sformatf("fast-source pulses actual %0d expected 6", pulses));

        // R8: reset raised while a pulse is high
        cut_ok = 1;
        @(negedge src_clk);
        src_evt = 1;
        @(posedge src_clk);
        exp_q.push_back($realtime);
        #0.2 src_evt = 0;
        @(posedge dst_pulse);
        #1 rst = 1;
        #0.5;
        check(dst_pulse == 0, "R8", $sformatf("output under reset actual %0b expected 0", dst_pulse));
        check(pulses == 7, "R8", $sformatf("pulses actual %0d expected 7", pulses));
        #20;
        cut_ok = 0;

        // R7: event on the first two source edges after release is dropped
        @(negedge src_clk);
        #0.5 rst = 0;
        src_evt = 1;
        @(posedge src_clk);
        @(posedge src_clk);
        #0.2 src_evt = 0;
        wait_dst(15);
        check(pulses == 7, "R7", $sformatf("pulses after early event actual %0d expected 7", pulses));
        check(dst_pulse == 0, "R8", $sformatf("output after re-release actual %0b expected 0", dst_pulse));

        // R7: a later event is still carried
        fire_event();
        wait_dst(5);
        check(pulses == 8, "R7", $sformatf("pulses after release actual %0d expected 8", pulses));
        check(exp_q.size() == 0, "R5", $sformatf("unmatched events actual %0d expected 0", exp_q.size()));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule